// File: doc/BRIEF.md
# Transmit Timeout Guard

A half-duplex line modem is steered between sending and listening by a single select bit that software owns. If the software hangs while the select bit says "send", the modem would jam the shared line for every other station. This block holds that select bit and pairs it with a 13-bit watchdog-style down-counter. The counter runs only while the modem is sending, and only on cycles where a prescaler tick is present. When it runs out, the block takes the select bit back to "listen" by itself and flags the event with a one-cycle pulse.

Software that legitimately needs a long transmission keeps it alive by writing a fixed key value to a second write address, the kick register. A kick reloads the counter to its full value. Any other value written there does nothing. Every switch from listening to sending also starts the counter from full. The block sees a plain write strobe with a one-bit register select and an 8-bit data byte. It reports the current mode and the timeout pulse.

Top module: `tx_guard`

## Requirements
- R1: While reset is asserted and right after its release, `tx_mode_o` is 0 (receive) and `timeout_o` is 0.
- R2: A write with `wr_sel_i`=0 (mode register) sets `tx_mode_o` to `wr_data_i[0]` at the next clock edge, 1 meaning transmit and 0 meaning receive. Data bits 7..1 are ignored.
- R3: A receive-to-transmit write loads the counter with 0x1FFF. With `tick_i` high on every cycle, transmit mode ends on the 8192nd clock edge after the edge that took the write.
- R4: The counter decrements only on edges where `tick_i` is high while in transmit mode. Cycles with `tick_i` low postpone the forced return by exactly their number.
- R5: When the count is zero in transmit mode and no valid kick is present, the next edge clears `tx_mode_o` and raises `timeout_o` for exactly one cycle.
- R6: A write with `wr_sel_i`=1 (kick register) and data 0xA2 reloads the counter to 0x1FFF. A further 8192 ticked edges are then needed before the forced return.
- R7: A kick-register write of any value other than 0xA2 has no effect on the counter or on the mode.
- R8: If a valid kick arrives in the cycle where the count is zero, the kick wins: transmit mode is kept, no timeout pulse is produced, and the count restarts from full.
- R9: In receive mode the counter holds its value and `timeout_o` stays 0 whatever `tick_i` does. A valid kick in receive mode does not select transmit.
- R10: A software write that returns the mode to receive produces no timeout pulse.
- R11: If the forced return and a mode-register write of 1 fall in the same cycle, the forced return wins and the mode becomes receive with a timeout pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 mode register, 1 kick register |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | Prescaler tick that advances the counter |
| tx_mode_o | output | 1 | Current mode: 1 transmit, 0 receive |
| timeout_o | output | 1 | One-cycle pulse on a forced return to receive |

## Verification
A keep-alive kick and the counter's expiry can coincide, and so can the expiry and a software mode write. The bench runs the counter down to zero with a tick on every edge, so the zero cycle is known exactly. In that cycle it issues a valid kick, an invalid kick value, or a mode write of 1. It judges each case by whether `tx_mode_o` survives that edge and whether `timeout_o` pulses. After a surviving kick, it runs a second full countdown to show that the count restarted from full.

// File: rtl/tx_guard_pkg.sv
package tx_guard_pkg;
  typedef enum logic {
    SEL_MODE = 1'b0,
    SEL_KICK = 1'b1
  } reg_sel_e;

  localparam int unsigned DEF_CNT_W  = 13;
  localparam int unsigned DEF_DATA_W = 8;
  localparam logic [7:0]  DEF_KEY    = 8'hA2;
endpackage

// File: rtl/tx_guard_rst_sync.sv
module tx_guard_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tx_guard_decode.sv
module tx_guard_decode
  import tx_guard_pkg::*;
#(
  parameter int unsigned      DATA_W = DEF_DATA_W,
  parameter logic [DATA_W-1:0] KEY   = DATA_W'(DEF_KEY)
) (
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              mode_wr_o,
  output logic              mode_val_o,
  output logic              kick_ok_o
);
  reg_sel_e sel;

  always_comb begin
    sel        = reg_sel_e'(wr_sel_i);
    mode_wr_o  = wr_en_i && (sel == SEL_MODE);
    mode_val_o = wr_data_i[0];
    kick_ok_o  = wr_en_i && (sel == SEL_KICK) && (wr_data_i == KEY);
  end
endmodule

// File: rtl/tx_guard_counter.sv
module tx_guard_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    zero_o = (cnt_q == '0);
    cnt_en = load_i || (run_i && !zero_o);
    cnt_d  = load_i ? FULL : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= FULL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tx_guard_mode.sv
module tx_guard_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wr_i,
  input  logic mode_val_i,
  input  logic kick_ok_i,
  input  logic zero_i,
  output logic tx_o,
  output logic expire_o,
  output logic pulse_o
);
  logic tx_q;
  logic tx_d;
  logic pulse_q;

  always_comb begin
    expire_o = tx_q && zero_i && !kick_ok_i;
    if (expire_o)       tx_d = 1'b0;
    else if (mode_wr_i) tx_d = mode_val_i;
    else                tx_d = tx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      tx_q    <= tx_d;
      pulse_q <= expire_o;
    end
  end

  assign tx_o    = tx_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/tx_guard.sv
module tx_guard
  import tx_guard_pkg::*;
#(
  parameter int unsigned       CNT_W       = DEF_CNT_W,
  parameter int unsigned       DATA_W      = DEF_DATA_W,
  parameter logic [DATA_W-1:0] KEY         = DATA_W'(DEF_KEY),
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic              tx_mode_o,
  output logic              timeout_o
);
  logic             rst_sync_n;
  logic             mode_wr_w;
  logic             mode_val_w;
  logic             kick_ok_w;
  logic             zero_w;
  logic             expire_w;
  logic             load_w;
  logic             run_w;
  logic             tx_w;
  logic [CNT_W-1:0] count_w;

  tx_guard_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tx_guard_decode #(.DATA_W(DATA_W), .KEY(KEY)) u_dec (
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .mode_wr_o  (mode_wr_w),
    .mode_val_o (mode_val_w),
    .kick_ok_o  (kick_ok_w)
  );

  // reload on a valid key or on entry into transmit
  assign load_w = kick_ok_w || (mode_wr_w && mode_val_w && !tx_w);
  assign run_w  = tx_w && tick_i;

  tx_guard_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .load_i  (load_w),
    .run_i   (run_w),
    .count_o (count_w),
    .zero_o  (zero_w)
  );

  tx_guard_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .mode_wr_i  (mode_wr_w),
    .mode_val_i (mode_val_w),
    .kick_ok_i  (kick_ok_w),
    .zero_i     (zero_w),
    .tx_o       (tx_w),
    .expire_o   (expire_w),
    .pulse_o    (timeout_o)
  );

  assign tx_mode_o = tx_w;
endmodule

// File: rtl/tx_guard_chk.sv
module tx_guard_chk #(
  parameter int unsigned       CNT_W  = 13,
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 8'hA2
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tx_mode_o,
  input logic              timeout_o,
  input logic [CNT_W-1:0]  count
);
  logic kick_seen;
  logic set_tx_seen;
  assign kick_seen   = wr_en_i && wr_sel_i && (wr_data_i == KEY);
  assign set_tx_seen = wr_en_i && !wr_sel_i && wr_data_i[0];

  // R5: the pulse follows a transmit cycle and lands in receive
  p_pulse_on_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |-> (!tx_mode_o && $past(tx_mode_o)));

  // R5: the pulse lasts one cycle
  p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R2: transmit is only entered by a mode write of 1
  p_entry_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(tx_mode_o) |-> $past(set_tx_seen));

  // R8: a valid kick while transmitting keeps transmit
  p_kick_keeps_tx_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_mode_o && kick_seen) |=> (tx_mode_o && !timeout_o));

  // R9: receive mode never produces a pulse
  p_quiet_in_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tx_mode_o |=> !timeout_o);

  // R9: counter frozen in receive without a load
  p_frozen_in_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!tx_mode_o && !kick_seen && !set_tx_seen) |=> $stable(count));

  // R6: a valid kick leaves the counter full
  p_kick_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    kick_seen |=> (count == {CNT_W{1'b1}}));
endmodule

bind tx_guard tx_guard_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .KEY(KEY)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .tx_mode_o (tx_mode_o),
  .timeout_o (timeout_o),
  .count     (count_w)
);

// File: tb/tx_guard_tb_top.sv
module tx_guard_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic       wr_sel_i;
  logic [7:0] wr_data_i;
  logic       tick_i;
  logic       tx_mode_o;
  logic       timeout_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  localparam int FULL_TICKS = 8191; // edges from full count down to zero

  always #10 clk_i = ~clk_i;

  tx_guard dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .tick_i    (tick_i),
    .tx_mode_o (tx_mode_o),
    .timeout_o (timeout_o)
  );

  // fields: en, sel, data[7:0], tick, exp_tx, exp_to
  localparam int NVEC = 9;
  localparam logic [12:0] VEC [0:NVEC-1] = '{
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},  // R9 idle in receive
    {1'b1, 1'b1, 8'hA2, 1'b1, 1'b0, 1'b0},  // R9 kick in receive
    {1'b1, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0},  // R2 select transmit
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},  // R2 holds
    {1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 1'b0},  // R7 bad key
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},  // R10 software clear
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},  // R10 no pulse after
    {1'b1, 1'b0, 8'h03, 1'b0, 1'b1, 1'b0},  // R2 bit0 set
    {1'b1, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0}   // R2 bit0 clear, bit1 ignored
  };

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(logic en, logic sel, logic [7:0] data, logic tk);
    wr_en_i   = en;
    wr_sel_i  = sel;
    wr_data_i = data;
    tick_i    = tk;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run_ticks(int n, logic tk);
    for (int i = 0; i < n; i++) apply(1'b0, 1'b0, 8'h00, tk);
  endtask

  task automatic enter_tx();
    apply(1'b1, 1'b0, 8'h01, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int pulses;
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = 8'h00; tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 tx in reset", tx_mode_o, 1'b0);
    check("R1 pulse in reset", timeout_o, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 tx after reset", tx_mode_o, 1'b0);
    check("R1 pulse after reset", timeout_o, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][12], VEC[v][11], VEC[v][10:3], VEC[v][2]);
      check($sformatf("table vec %0d tx", v), tx_mode_o, VEC[v][1]);
      check($sformatf("table vec %0d pulse", v), timeout_o, VEC[v][0]);
    end

    // R3: full countdown
    enter_tx();
    run_ticks(FULL_TICKS, 1'b1);
    check("R3 tx at zero count", tx_mode_o, 1'b1);
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    check("R3 forced return", tx_mode_o, 1'b0);
    check("R5 pulse raised", timeout_o, 1'b1);
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    check("R5 pulse one cycle", timeout_o, 1'b0);

    // R4: tick-low cycles postpone expiry
    enter_tx();
    run_ticks(4000, 1'b1);
    run_ticks(700, 1'b0);
    run_ticks(FULL_TICKS - 4000, 1'b1);
    check("R4 tx held by idle ticks", tx_mode_o, 1'b1);
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    check("R4 return after ticked count", tx_mode_o, 1'b0);

    // R6: kick mid-run reloads full
    enter_tx();
    run_ticks(5000, 1'b1);
    apply(1'b1, 1'b1, 8'hA2, 1'b1);
    run_ticks(FULL_TICKS, 1'b1);
    check("R6 tx alive after kick", tx_mode_o, 1'b1);
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    check("R6 return after reloaded count", tx_mode_o, 1'b0);

    // R8: kick at zero wins
    enter_tx();
    run_ticks(FULL_TICKS, 1'b1);
    apply(1'b1, 1'b1, 8'hA2, 1'b1);
    check("R8 tx kept", tx_mode_o, 1'b1);
    check("R8 no pulse", timeout_o, 1'b0);
    run_ticks(FULL_TICKS, 1'b1);
    check("R8 count restarted", tx_mode_o, 1'b1);
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    check("R8 later expiry", tx_mode_o, 1'b0);

    // R7: wrong key at zero does not save transmit
    enter_tx();
    run_ticks(FULL_TICKS, 1'b1);
    apply(1'b1, 1'b1, 8'hA3, 1'b1);
    check("R7 wrong key ignored tx", tx_mode_o, 1'b0);
    check("R7 wrong key ignored pulse", timeout_o, 1'b1);

    // R11: mode write of 1 at zero loses to expiry
    enter_tx();
    run_ticks(FULL_TICKS, 1'b1);
    apply(1'b1, 1'b0, 8'h01, 1'b1);
    check("R11 expiry wins tx", tx_mode_o, 1'b0);
    check("R11 expiry wins pulse", timeout_o, 1'b1);

    // R9: long idle in receive
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    pulses = 0;
    for (int i = 0; i < 9000; i++) begin
      apply(1'b0, 1'b0, 8'h00, 1'b1);
      if (timeout_o) pulses++;
    end
    check("R9 no pulse in receive", pulses != 0, 1'b0);
    check("R9 still receive", tx_mode_o, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule